// File: doc/BRIEF.md
# GPIO Interrupt Source Selector and Trigger Detector

This block is the interrupt front end for a bank of general purpose pad inputs. It has eight interrupt lines. Each line takes any one of 62 pad inputs through a 7-bit select. The chosen pad is turned into an interrupt request by a detector that works in one of three ways: level-sensitive with a programmable active sense, single-edge with a programmable direction, or any-edge. One master bit gates every line. The eight outputs drive a downstream interrupt controller. That controller handles acknowledge and priority.

All 62 pads are synchronised with two flops before the select, so a select change never meets a metastable value. Software sets up the block through five 32-bit control words on a simple write strobe and address port, and it can read them back combinationally. Register 0 holds the mode, sense and master bits. Registers 1 to 4 each hold two line selects. The pads are grouped into five banks of 13, 7, 17, 13 and 12 pads, which take indices 0 to 61 in that order. Every index is reachable from every line.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset every control register reads zero and all eight interrupt outputs are low.
- R2: Register 0 keeps bit 31 (master), bits 23:16 (any-edge per line), bits 15:8 (single-edge per line) and bits 7:0 (sense per line), with bit n of each field belonging to line n. Register X (1..4) keeps bits 6:0 as the select of line 2X-2 and bits 22:16 as the select of line 2X-1. All other bits, and addresses 5 to 7, read zero and ignore writes.
- R3: While the master bit is clear, all interrupt outputs are low one clock after the register update, whatever the pads do.
- R4: With both mode bits of a line clear, the output follows the selected pad, XOR its sense bit. It lags a pad change by three clocks and a configuration change by one clock.
- R5: In single-edge mode with sense 0, a rising edge on the selected pad gives exactly one clock high on the output, three clocks after the pad change. A falling edge gives nothing.
- R6: In single-edge mode with sense 1, only a falling edge gives the one-clock pulse.
- R7: The any-edge bit overrides the single-edge bit and the sense bit. Every change of the selected pad gives a one-clock pulse.
- R8: A select value from 62 to 127 keeps its line low in every mode and sense.
- R9: For two clocks after a select write changes a line's source, an edge-mode line produces no pulse from the switch of source itself.
- R10: Each line can reach pads at both ends of every bank (0, 12, 13, 19, 20, 36, 37, 49, 50, 61).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control registers |
| reg_addr | input | 3 | Register index (0 to 4 in use) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pad_in | input | 62 | Asynchronous pad inputs |
| irq_out | output | 8 | Per-line interrupt requests |

## Verification
The assertions assume that the write port is quiet between configuration steps. They also assume that a pad does not change on consecutive clocks while its line is in an edge mode, so one clock high can be taken to mean one detected edge. The stimulus holds each pad value for at least four clocks and changes one setting per write. It lets the synchronisers settle before any expected value is pushed to the scoreboard. Select-change suppression is exercised with the old and new pads at opposite levels. Without suppression, that switch would look like a real edge.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int NUM_PADS   = 62;
  localparam int NUM_LINES  = 8;
  localparam int SEL_W      = 7;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  // control word 0 field offsets (software visible)
  localparam int SENSE_LSB  = 0;
  localparam int ONE_LSB    = 8;
  localparam int ANY_LSB    = 16;
  localparam int MASTER_BIT = 31;
  // second select within a select word
  localparam int HI_SEL_LSB = 16;

  // edge decision: any-edge wins, otherwise sense picks the direction
  function automatic logic edge_fire(logic cur, logic old, logic sense, logic any_edge);
    if (any_edge) return cur ^ old;
    return sense ? (old & ~cur) : (cur & ~old);
  endfunction

  // level decision: sense 1 means active low
  function automatic logic level_fire(logic cur, logic sense);
    return cur ^ sense;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int WIDTH = 62
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int LINES = NUM_LINES,
  parameter int SW    = SEL_W,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [AW-1:0]          reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  output logic                   master_en,
  output logic [LINES-1:0]       sense_v,
  output logic [LINES-1:0]       one_v,
  output logic [LINES-1:0]       any_v,
  output logic [LINES-1:0][SW-1:0] sel_v
);
  localparam logic [DW-1:0] LINE_ONES = DW'((64'd1 << LINES) - 64'd1);
  localparam logic [DW-1:0] CTRL_MASK = (DW'(1) << MASTER_BIT) | (LINE_ONES << SENSE_LSB)
                                      | (LINE_ONES << ONE_LSB) | (LINE_ONES << ANY_LSB);

  logic [DW-1:0]           ctrl_q;
  logic [LINES-1:0][SW-1:0] sel_q;

  function automatic logic [AW-1:0] word_of(int line);
    return AW'(line / 2 + 1);
  endfunction

  function automatic int lsb_of(int line);
    return (line % 2 == 1) ? HI_SEL_LSB : 0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == '0) ctrl_q <= reg_wdata & CTRL_MASK;
      for (int k = 0; k < LINES; k++) begin
        if (reg_addr == word_of(k)) sel_q[k] <= reg_wdata[lsb_of(k) +: SW];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = ctrl_q;
    for (int k = 0; k < LINES; k++) begin
      if (reg_addr == word_of(k)) reg_rdata[lsb_of(k) +: SW] = sel_q[k];
    end
  end

  assign master_en = ctrl_q[MASTER_BIT];
  assign sense_v   = ctrl_q[SENSE_LSB +: LINES];
  assign one_v     = ctrl_q[ONE_LSB +: LINES];
  assign any_v     = ctrl_q[ANY_LSB +: LINES];
  assign sel_v     = sel_q;

  // R2: a write to word 0 lands masked on the next clock
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0) |=> (ctrl_q == ($past(reg_wdata) & CTRL_MASK)));
  // R2: bits outside the defined fields stay zero
  assert_ctrl_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: rtl/gpio_irq_line.sv
`timescale 1ns/1ps
module gpio_irq_line
  import gpio_irq_pkg::*;
#(
  parameter int PADS = NUM_PADS,
  parameter int SW   = SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PADS-1:0] pads_s,
  input  logic [SW-1:0]   sel,
  input  logic            sense,
  input  logic            one_edge,
  input  logic            any_edge,
  input  logic            enable,
  output logic            irq
);
  function automatic logic pick(logic [PADS-1:0] v, logic [SW-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < PADS; i++) begin
      if (s == SW'(i)) r = v[i];
    end
    return r;
  endfunction

  logic          sel_ok;
  logic          picked;
  logic          prev_q;
  logic [SW-1:0] sel_q;
  logic          sel_moved;
  logic          edge_mode;
  logic          edge_hit;
  logic          level_hit;
  logic          line_hit;
  logic          irq_q;

  assign sel_ok    = (sel < SW'(PADS));
  assign picked    = pick(pads_s, sel);
  assign sel_moved = (sel != sel_q);
  assign edge_mode = one_edge | any_edge;
  assign edge_hit  = edge_fire(picked, prev_q, sense, any_edge) & ~sel_moved;
  assign level_hit = level_fire(picked, sense);
  assign line_hit  = enable & sel_ok & (edge_mode ? edge_hit : level_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= picked;
      sel_q  <= sel;
      irq_q  <= line_hit;
    end
  end

  assign irq = irq_q;

  // R8: an out-of-range select never produces a request
  assert_bad_sel_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> !irq_q);
  // R9: no pulse from the cycle in which the source changed
  assert_switch_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_moved && edge_mode) |=> !irq_q);
  // R5: a rising-only pulse is backed by a real low-to-high step
  assert_rise_backed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && $past(one_edge && !any_edge && !sense)) |-> ($past(picked) && !$past(prev_q)));
endmodule

// File: rtl/gpio_irq_front.sv
`timescale 1ns/1ps
module gpio_irq_front
  import gpio_irq_pkg::*;
#(
  parameter int PADS  = NUM_PADS,
  parameter int LINES = NUM_LINES,
  parameter int SW    = SEL_W,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [PADS-1:0]  pad_in,
  output logic [LINES-1:0] irq_out
);
  logic                     master_en;
  logic [LINES-1:0]         sense_v;
  logic [LINES-1:0]         one_v;
  logic [LINES-1:0]         any_v;
  logic [LINES-1:0][SW-1:0] sel_v;
  logic [PADS-1:0]          pads_s;

  gpio_irq_regs #(.LINES(LINES), .SW(SW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .master_en(master_en),
    .sense_v(sense_v), .one_v(one_v), .any_v(any_v), .sel_v(sel_v)
  );

  gpio_irq_sync #(.WIDTH(PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pads_s)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    gpio_irq_line #(.PADS(PADS), .SW(SW)) u_line (
      .clk(clk), .rst_n(rst_n), .pads_s(pads_s), .sel(sel_v[g]),
      .sense(sense_v[g]), .one_edge(one_v[g]), .any_edge(any_v[g]),
      .enable(master_en), .irq(irq_out[g])
    );
  end

  // R3: master off silences every line on the following clock
  assert_master_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (irq_out == '0));
endmodule

// File: tb/test_gpio_irq_front.sv
`timescale 1ns/1ps
module test_gpio_irq_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [61:0] pad_in = '0;
  logic [7:0]  irq_out;

  gpio_irq_front i_gpio_irq_front (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in), .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  exp_t mon_e;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations in their cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      mon_e = sbq.pop_front();
      checks++;
      if (mon_e.cyc != cyc || irq_out !== mon_e.val) begin
        failures++;
        $display("FAIL %s cycle %0d: irq_out actual=%h expected=%h", mon_e.tag, cyc, irq_out, mon_e.val);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    step(1);
    reg_we    = 1'b0;
  endtask

  task automatic expect_at(int d, logic [7:0] v, string tag);
    sbq.push_back('{cyc + d, v, tag});
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  int pads_a[8] = '{0, 12, 13, 19, 20, 36, 37, 49};

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    chk(irq_out === 8'h00, "R1 irq after reset", 32'(irq_out), 32'h0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R1 reg reset");

    // R2: field masking and unused addresses
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk(3'd0, 32'h80FF_FFFF, "R2 ctrl mask");
    wr(3'd1, 32'hFFFF_FFFF);
    rd_chk(3'd1, 32'h007F_007F, "R2 select mask");
    wr(3'd4, 32'h0023_0011);
    rd_chk(3'd4, 32'h0023_0011, "R2 select word 4");
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk(3'd5, 32'h0, "R2 unused address");
    rd_chk(3'd2, 32'h0, "R2 untouched word");
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd4, 32'h0);
    step(4);

    // R4: level mode, both senses
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h8000_0000);
    expect_at(1, 8'h00, "R4 idle low");
    step(3);
    pad_in[5] = 1'b1;
    expect_at(2, 8'h00, "R4 latency");
    expect_at(3, 8'h01, "R4 follow high");
    step(5);
    pad_in[5] = 1'b0;
    expect_at(2, 8'h01, "R4 latency fall");
    expect_at(3, 8'h00, "R4 follow low");
    step(5);
    wr(3'd0, 32'h8000_0001);
    expect_at(1, 8'h01, "R4 active low");
    step(3);

    // R3: master clear
    wr(3'd0, 32'h0000_0001);
    expect_at(1, 8'h00, "R3 master off");
    pad_in[5] = 1'b1;
    expect_at(3, 8'h00, "R3 pad high ignored");
    step(5);
    pad_in[5] = 1'b0;
    expect_at(3, 8'h00, "R3 pad low ignored");
    step(5);

    // R5: single edge, rising
    wr(3'd0, 32'h8000_0100);
    expect_at(1, 8'h00, "R5 idle");
    step(3);
    pad_in[5] = 1'b1;
    expect_at(2, 8'h00, "R5 before pulse");
    expect_at(3, 8'h01, "R5 rising pulse");
    expect_at(4, 8'h00, "R5 pulse one clock");
    step(6);
    pad_in[5] = 1'b0;
    expect_at(3, 8'h00, "R5 falling ignored");
    expect_at(4, 8'h00, "R5 falling ignored");
    step(6);

    // R6: single edge, falling
    wr(3'd0, 32'h8000_0101);
    step(3);
    pad_in[5] = 1'b1;
    expect_at(3, 8'h00, "R6 rising ignored");
    expect_at(4, 8'h00, "R6 rising ignored");
    step(6);
    pad_in[5] = 1'b0;
    expect_at(2, 8'h00, "R6 before pulse");
    expect_at(3, 8'h01, "R6 falling pulse");
    expect_at(4, 8'h00, "R6 pulse one clock");
    step(6);

    // R7: any edge overrides single edge and sense
    wr(3'd0, 32'h8001_0101);
    step(3);
    pad_in[5] = 1'b1;
    expect_at(3, 8'h01, "R7 rise pulse");
    expect_at(4, 8'h00, "R7 rise one clock");
    step(6);
    pad_in[5] = 1'b0;
    expect_at(3, 8'h01, "R7 fall pulse");
    expect_at(4, 8'h00, "R7 fall one clock");
    step(6);

    // R8: out-of-range selects, line 1 level active low
    wr(3'd1, (32'd62 << 16) | 32'd5);
    wr(3'd0, 32'h8000_0002);
    expect_at(1, 8'h00, "R8 select 62");
    step(4);
    wr(3'd1, (32'd127 << 16) | 32'd5);
    expect_at(1, 8'h00, "R8 select 127");
    step(4);
    wr(3'd1, (32'd6 << 16) | 32'd5);
    expect_at(1, 8'h02, "R8 valid select contrast");
    step(4);

    // R9: source switch between pads at opposite levels
    wr(3'd1, 32'd5);
    pad_in[6] = 1'b1;
    wr(3'd0, 32'h8001_0000);
    step(4);
    expect_at(1, 8'h00, "R9 settled");
    step(2);
    wr(3'd1, 32'd6);
    expect_at(1, 8'h00, "R9 switch masked");
    expect_at(2, 8'h00, "R9 switch masked");
    step(5);
    pad_in[6] = 1'b0;
    expect_at(3, 8'h01, "R9 real edge after switch");
    expect_at(4, 8'h00, "R9 real edge one clock");
    step(6);

    // R10: bank boundary pads on every line
    wr(3'd0, 32'h0);
    pad_in = '0;
    for (int k = 1; k <= 4; k++)
      wr(3'(k), (32'(pads_a[2*k-1]) << 16) | 32'(pads_a[2*k-2]));
    wr(3'd0, 32'h8000_0000);
    step(4);
    for (int i = 0; i < 8; i++) begin
      pad_in = 62'd1 << pads_a[i];
      expect_at(3, 8'(1 << i), "R10 boundary pad");
      step(4);
      pad_in = '0;
      expect_at(3, 8'h00, "R10 release");
      step(4);
    end
    wr(3'd1, (32'd61 << 16) | 32'd50);
    step(4);
    pad_in = 62'd1 << 50;
    expect_at(3, 8'h01, "R10 pad 50");
    step(4);
    pad_in = 62'd1 << 61;
    expect_at(3, 8'h02, "R10 pad 61");
    step(6);

    chk(sbq.size() == 0, "scoreboard drained", 32'(sbq.size()), 32'h0);
    report();
  end
endmodule